// File: doc/BRIEF.md
# Word ALU with Auxiliary Side-Result Register

This block is the integer execute stage of a small 16-bit processor. It takes an operation code, a destination operand `b` and a source operand `a`, and returns the new value for `b` in the same cycle. Most arithmetic and shift operations also produce a second 16-bit word: the high half of a product, the fractional part of a quotient, the bits shifted out, or a carry or borrow indication. That word goes to a clocked auxiliary register.

The auxiliary register feeds back into the unit, so the add-with-carry and subtract-with-carry operations can chain multi-word arithmetic. Operand fetch, instruction decode and writeback of `b` are handled elsewhere. The surrounding core can also load the auxiliary register directly, as an ordinary register move. Division, including the fractional word, completes in a single cycle.

Top module: `word_alu_aux`

## Requirements
- R1: Operation codes are `op` = 0 ADD, 1 SUB, 2 ADDC, 3 SUBC, 4 MULU, 5 MULS, 6 DIVU, 7 DIVS, 8 REMU, 9 REMS, 10 AND, 11 OR, 12 XOR, 13 SRL, 14 SRA, 15 SLL. ADD returns (b+a) mod 2^16, and its aux word is 1 on unsigned carry-out, else 0. SUB returns (b-a) mod 2^16, and its aux word is 0xFFFF on unsigned borrow, else 0.
- R2: ADDC returns b+a+aux mod 2^16, with aux word 1 when the full sum exceeds 0xFFFF, else 0. SUBC returns b-a+aux mod 2^16. Its aux word is 0xFFFF when the exact value is negative, 1 when it exceeds 0xFFFF, and 0 otherwise. For example, b=0x7FFF, a=0, aux=0xFFFF gives 0x7FFE with aux 1.
- R3: MULU (unsigned) and MULS (two's-complement) return product bits 15..0, with product bits 31..16 as the aux word.
- R4: DIVU returns b/a unsigned, with aux word ((b<<16)/a) mod 2^16. DIVS does the same on sign-extended operands and truncates toward zero (24 / -20 gives -1).
- R5: With a = 0, DIVU and DIVS return 0 with aux word 0, and REMU and REMS return 0.
- R6: REMU returns b mod a. REMS returns the signed remainder with the sign of the dividend (-7 rem 16 gives -7).
- R7: SRL zero-fills, with aux word ((b<<16)>>a) mod 2^16. SRA keeps the sign and has the same aux word as SRL. SLL has aux word ((b<<a)>>16) mod 2^16. Any shift amount up to 0xFFFF is defined: at 16 or more, SRL and SLL return 0 and SRA returns copies of the sign bit.
- R8: AND, OR, XOR, REMU and REMS hold `aux_we` low and leave `aux_q` unchanged.
- R9: `aux_q` resets to 0. It takes `aux_new` at the clock edge where `issue` and `aux_we` are both high. Otherwise it takes `aux_load_val` when `aux_load` is high. If both apply in the same cycle, the operation result wins.
- R10: `res`, `aux_new` and `aux_we` are combinational functions of `op`, `opnd_b`, `opnd_a`, `issue` and `aux_q`. `aux_we` is high for every operation code not listed in R8 while `issue` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An operation is executed this cycle |
| op | input | 4 | Operation code (R1) |
| opnd_b | input | 16 | Destination operand b |
| opnd_a | input | 16 | Source operand a |
| aux_load | input | 1 | Direct load of the auxiliary register |
| aux_load_val | input | 16 | Value for the direct load |
| res | output | 16 | New value for b |
| aux_new | output | 16 | Side result of the operation |
| aux_we | output | 1 | Side result is written this cycle |
| aux_q | output | 16 | Current auxiliary register |

## Verification
The embedded properties are checked on every cycle. They cover the value sets the carry and borrow words may take, the zeros produced on a zero divisor, and sign fill on wide arithmetic shifts. They also check that the auxiliary register holds across logic and remainder operations and takes a direct load when no operation writes it. Exact numeric results cannot be covered that way: products, truncating signed division at 0x8000 / -1, fraction words and shift-out bits are shown only by the bench. The bench compares them against a 64-bit integer model over corner operands and seeded random operands. Chained carry behaviour also relies on the bench, which follows the register from operation to operation.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_MULU = 4'd4,
    OP_MULS = 4'd5,
    OP_DIVU = 4'd6,
    OP_DIVS = 4'd7,
    OP_REMU = 4'd8,
    OP_REMS = 4'd9,
    OP_AND  = 4'd10,
    OP_OR   = 4'd11,
    OP_XOR  = 4'd12,
    OP_SRL  = 4'd13,
    OP_SRA  = 4'd14,
    OP_SLL  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    AS_ADD  = 2'd0,
    AS_SUB  = 2'd1,
    AS_ADDC = 2'd2,
    AS_SUBC = 2'd3
  } addsub_kind_e;

  typedef enum logic [1:0] {
    SH_SRL = 2'd0,
    SH_SRA = 2'd1,
    SH_SLL = 2'd2
  } shift_kind_e;

endpackage

// File: rtl/word_alu_addsub.sv
module word_alu_addsub
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  addsub_kind_e     kind,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     aux,
  output logic [W-1:0]     res,
  output logic [W-1:0]     side
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W:0]   sum1;
  logic [W:0]   dif1;
  logic [W+1:0] sum2;
  logic [W+1:0] dif2;

  // two extra bits hold b - a + aux exactly: range -(2^W-1) .. 2^(W+1)-2
  assign sum1 = {1'b0, b} + {1'b0, a};
  assign dif1 = {1'b0, b} - {1'b0, a};
  assign sum2 = {2'b00, b} + {2'b00, a} + {2'b00, aux};
  assign dif2 = {2'b00, b} - {2'b00, a} + {2'b00, aux};

  always_comb begin
    unique case (kind)
      AS_ADD: begin
        res  = sum1[W-1:0];
        side = sum1[W] ? ONE : '0;
      end
      AS_SUB: begin
        res  = dif1[W-1:0];
        side = dif1[W] ? ONES : '0;
      end
      AS_ADDC: begin
        res  = sum2[W-1:0];
        side = (sum2[W+1] | sum2[W]) ? ONE : '0;
      end
      default: begin
        res  = dif2[W-1:0];
        if (dif2[W+1])     side = ONES;
        else if (dif2[W])  side = ONE;
        else               side = '0;
      end
    endcase
  end
endmodule

// File: rtl/word_alu_muldiv.sv
module word_alu_muldiv #(
  parameter int W = 16
) (
  input  logic         is_div,
  input  logic         is_signed,
  input  logic         want_rem,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic [W-1:0] side
);
  localparam int W2 = 2 * W;

  logic [W2-1:0]        prod_u;
  logic signed [W2-1:0] prod_s;
  logic                 den_zero;
  logic signed [W:0]    sb;
  logic signed [W:0]    sa;
  logic signed [W2:0]   s_num;
  logic signed [W2:0]   s_den;
  logic [W-1:0]         uq, uf, ur, sq, sf, sr;

  assign prod_u = {{W{1'b0}}, b} * {{W{1'b0}}, a};
  assign prod_s = $signed(b) * $signed(a);

  assign den_zero = (a == '0);
  assign sb    = {b[W-1], b};
  assign sa    = {a[W-1], a};
  assign s_num = {b[W-1], b, {W{1'b0}}};
  assign s_den = {{(W+1){a[W-1]}}, a};

  // zero divisor is steered to zero before the quotient is used
  assign uq = den_zero ? '0 : W'(b / a);
  assign uf = den_zero ? '0 : W'({b, {W{1'b0}}} / {{W{1'b0}}, a});
  assign ur = den_zero ? '0 : W'(b % a);
  assign sq = den_zero ? '0 : W'(sb / sa);
  assign sf = den_zero ? '0 : W'(s_num / s_den);
  assign sr = den_zero ? '0 : W'(sb % sa);

  always_comb begin
    if (!is_div) begin
      res  = is_signed ? prod_s[W-1:0]  : prod_u[W-1:0];
      side = is_signed ? prod_s[W2-1:W] : prod_u[W2-1:W];
    end else if (want_rem) begin
      res  = is_signed ? sr : ur;
      side = '0;
    end else begin
      res  = is_signed ? sq : uq;
      side = is_signed ? sf : uf;
    end
  end
endmodule

// File: rtl/word_alu_shift.sv
module word_alu_shift
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  shift_kind_e  kind,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic [W-1:0] side
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] r_right;
  logic [W2-1:0] r_left;
  logic [W-1:0]  r_arith;

  // double-width intermediates keep shifted-out bits; large amounts give 0
  assign r_right = {b, {W{1'b0}}} >> a;
  assign r_left  = {{W{1'b0}}, b} << a;
  assign r_arith = W'($signed(b) >>> a);

  always_comb begin
    unique case (kind)
      SH_SRL:  begin res = r_right[W2-1:W]; side = r_right[W-1:0]; end
      SH_SRA:  begin res = r_arith;         side = r_right[W-1:0]; end
      default: begin res = r_left[W-1:0];   side = r_left[W2-1:W]; end
    endcase
  end
endmodule

// File: rtl/word_alu_aux.sv
module word_alu_aux
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [3:0]   op,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] opnd_a,
  input  logic         aux_load,
  input  logic [W-1:0] aux_load_val,
  output logic [W-1:0] res,
  output logic [W-1:0] aux_new,
  output logic         aux_we,
  output logic [W-1:0] aux_q
);
  alu_op_e      op_e;
  addsub_kind_e as_kind;
  shift_kind_e  sh_kind;
  logic [W-1:0] as_res, as_side, md_res, md_side, sh_res, sh_side;
  logic         md_div, md_signed, md_rem;
  logic         alu_we;
  logic [W-1:0] alu_res, alu_side;
  logic [W-1:0] aux_d;
  logic         aux_en;

  assign op_e = alu_op_e'(op);

  always_comb begin
    as_kind   = AS_ADD;
    sh_kind   = SH_SRL;
    md_div    = 1'b0;
    md_signed = 1'b0;
    md_rem    = 1'b0;
    alu_we    = 1'b1;
    alu_res   = '0;
    alu_side  = '0;
    unique case (op_e)
      OP_ADD:  begin as_kind = AS_ADD;  alu_res = as_res; alu_side = as_side; end
      OP_SUB:  begin as_kind = AS_SUB;  alu_res = as_res; alu_side = as_side; end
      OP_ADDC: begin as_kind = AS_ADDC; alu_res = as_res; alu_side = as_side; end
      OP_SUBC: begin as_kind = AS_SUBC; alu_res = as_res; alu_side = as_side; end
      OP_MULU: begin alu_res = md_res; alu_side = md_side; end
      OP_MULS: begin md_signed = 1'b1; alu_res = md_res; alu_side = md_side; end
      OP_DIVU: begin md_div = 1'b1; alu_res = md_res; alu_side = md_side; end
      OP_DIVS: begin
        md_div = 1'b1; md_signed = 1'b1; alu_res = md_res; alu_side = md_side;
      end
      OP_REMU: begin md_div = 1'b1; md_rem = 1'b1; alu_res = md_res; alu_we = 1'b0; end
      OP_REMS: begin
        md_div = 1'b1; md_rem = 1'b1; md_signed = 1'b1; alu_res = md_res; alu_we = 1'b0;
      end
      OP_AND:  begin alu_res = opnd_b & opnd_a; alu_we = 1'b0; end
      OP_OR:   begin alu_res = opnd_b | opnd_a; alu_we = 1'b0; end
      OP_XOR:  begin alu_res = opnd_b ^ opnd_a; alu_we = 1'b0; end
      OP_SRL:  begin sh_kind = SH_SRL; alu_res = sh_res; alu_side = sh_side; end
      OP_SRA:  begin sh_kind = SH_SRA; alu_res = sh_res; alu_side = sh_side; end
      default: begin sh_kind = SH_SLL; alu_res = sh_res; alu_side = sh_side; end
    endcase
  end

  word_alu_addsub #(.W(W)) u_addsub (
    .kind (as_kind), .b (opnd_b), .a (opnd_a), .aux (aux_q),
    .res  (as_res),  .side (as_side)
  );

  word_alu_muldiv #(.W(W)) u_muldiv (
    .is_div (md_div), .is_signed (md_signed), .want_rem (md_rem),
    .b (opnd_b), .a (opnd_a), .res (md_res), .side (md_side)
  );

  word_alu_shift #(.W(W)) u_shift (
    .kind (sh_kind), .b (opnd_b), .a (opnd_a), .res (sh_res), .side (sh_side)
  );

  assign res     = alu_res;
  assign aux_new = alu_side;
  assign aux_we  = issue & alu_we;

  // next state of the auxiliary register: operation result before direct load
  always_comb begin
    aux_en = 1'b0;
    aux_d  = aux_q;
    if (aux_we) begin
      aux_en = 1'b1;
      aux_d  = alu_side;
    end else if (aux_load) begin
      aux_en = 1'b1;
      aux_d  = aux_load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      aux_q <= '0;
    else if (aux_en) aux_q <= aux_d;
  end

  p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_e == OP_ADD |-> (aux_new == W'(0) || aux_new == W'(1)));

  p_sub_borrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_e == OP_SUB |-> (aux_new == '0 || aux_new == {W{1'b1}}));

  p_subc_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_e == OP_SUBC |->
      (aux_new == '0 || aux_new == W'(1) || aux_new == {W{1'b1}}));

  p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op_e == OP_DIVU || op_e == OP_DIVS || op_e == OP_REMU || op_e == OP_REMS)
      && opnd_a == '0 |-> res == '0);

  p_sra_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_e == OP_SRA && opnd_a >= W[W-1:0] |-> res == {W{opnd_b[W-1]}});

  p_aux_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !aux_load && (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR ||
      op_e == OP_REMU || op_e == OP_REMS) |=> $stable(aux_q));

  p_aux_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue && aux_load |=> aux_q == $past(aux_load_val));

endmodule

// File: tb/word_alu_aux_test.sv
module word_alu_aux_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [3:0]  op;
  logic [15:0] opnd_b, opnd_a, aux_load_val;
  logic        aux_load;
  logic [15:0] res, aux_new, aux_q;
  logic        aux_we;

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  logic [15:0] mdl_aux;

  always #(CLK_PERIOD / 2) clk = ~clk;

  word_alu_aux #(.W(16)) uut (
    .clk (clk), .rst_n (rst_n), .issue (issue), .op (op),
    .opnd_b (opnd_b), .opnd_a (opnd_a), .aux_load (aux_load),
    .aux_load_val (aux_load_val), .res (res), .aux_new (aux_new),
    .aux_we (aux_we), .aux_q (aux_q)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd5:   return "R3";
      4'd6, 4'd7:   return "R4";
      4'd8, 4'd9:   return "R6";
      4'd10, 4'd11, 4'd12: return "R8";
      default:      return "R7";
    endcase
  endfunction

  // independent model on 64-bit integers
  function automatic void ref_model(input logic [3:0] o, input logic [15:0] b,
                                    input logic [15:0] a, input logic [15:0] x,
                                    output logic [15:0] r, output logic [15:0] e,
                                    output logic w);
    longint ub, ua, ux, sb, sa, t;
    ub = longint'(b); ua = longint'(a); ux = longint'(x);
    sb = longint'($signed(b)); sa = longint'($signed(a));
    w = 1'b1; r = 16'h0; e = 16'h0;
    case (o)
      4'd0: begin t = ub + ua; r = 16'(t); e = (t > 65535) ? 16'h1 : 16'h0; end
      4'd1: begin t = ub - ua; r = 16'(t); e = (t < 0) ? 16'hFFFF : 16'h0; end
      4'd2: begin t = ub + ua + ux; r = 16'(t); e = (t > 65535) ? 16'h1 : 16'h0; end
      4'd3: begin
        t = ub - ua + ux; r = 16'(t);
        e = (t < 0) ? 16'hFFFF : ((t > 65535) ? 16'h1 : 16'h0);
      end
      4'd4: begin t = ub * ua; r = 16'(t); e = 16'(t >> 16); end
      4'd5: begin t = sb * sa; r = 16'(t); e = 16'(t >>> 16); end
      4'd6: if (ua != 0) begin r = 16'(ub / ua); e = 16'((ub * 65536) / ua); end
      4'd7: if (sa != 0) begin r = 16'(sb / sa); e = 16'((sb * 65536) / sa); end
      4'd8: begin w = 1'b0; if (ua != 0) r = 16'(ub % ua); end
      4'd9: begin w = 1'b0; if (sa != 0) r = 16'(sb % sa); end
      4'd10: begin w = 1'b0; r = b & a; end
      4'd11: begin w = 1'b0; r = b | a; end
      4'd12: begin w = 1'b0; r = b ^ a; end
      4'd13: begin t = (ub * 65536) >> ua; r = 16'(t >> 16); e = 16'(t); end
      4'd14: begin r = 16'(sb >>> ua); e = 16'(((ub * 65536) >> ua)); end
      default: begin t = ub << ua; r = 16'(t); e = 16'(t >> 16); end
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [15:0] b, input logic [15:0] a);
    logic [15:0] r, e;
    logic        w;
    @(negedge clk);
    check("R9", aux_q === mdl_aux, "aux_q before op", aux_q, mdl_aux);
    issue = 1'b1; op = o; opnd_b = b; opnd_a = a; aux_load = 1'b0;
    #1;
    ref_model(o, b, a, mdl_aux, r, e, w);
    check(req_of(o), res === r, $sformatf("res op%0d b=%h a=%h", o, b, a), res, r);
    check("R10", aux_we === w, $sformatf("aux_we op%0d", o), {15'h0, aux_we}, {15'h0, w});
    if (w) begin
      check(req_of(o), aux_new === e, $sformatf("aux op%0d b=%h a=%h x=%h", o, b, a, mdl_aux),
            aux_new, e);
      mdl_aux = e;
    end
  endtask

  task automatic load_aux(input logic [15:0] v);
    @(negedge clk);
    issue = 1'b0; aux_load = 1'b1; aux_load_val = v;
    mdl_aux = v;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] corner [5];
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
    corner[3] = 16'h8000; corner[4] = 16'hFFFF;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; issue = 1'b0; op = 4'd0; opnd_b = '0; opnd_a = '0;
    aux_load = 1'b0; aux_load_val = '0; mdl_aux = '0;
    repeat (3) @(negedge clk);
    check("R9", aux_q === 16'h0, "aux_q in reset", aux_q, 16'h0);
    rst_n = 1'b1;

    // R2 worked example: 0x7FFF - 0 + 0xFFFF
    load_aux(16'hFFFF);
    run_op(4'd3, 16'h7FFF, 16'h0000);
    // R4 truncation toward zero, R6 remainder sign, R5 zero divisor
    run_op(4'd7, 16'd24, 16'hFFEC);
    run_op(4'd9, 16'hFFF9, 16'd16);
    run_op(4'd6, 16'd12, 16'd0);
    run_op(4'd7, 16'h8000, 16'hFFFF);
    run_op(4'd8, 16'd12, 16'd0);
    // R7 shift amounts at and beyond the word width
    run_op(4'd14, 16'h8001, 16'd16);
    run_op(4'd13, 16'hABCD, 16'd16);
    run_op(4'd15, 16'hABCD, 16'd16);
    run_op(4'd15, 16'hABCD, 16'd40);
    run_op(4'd14, 16'h4001, 16'hFFFF);

    // R8: logic and remainder ops keep aux after a known load
    load_aux(16'h5A5A);
    run_op(4'd10, 16'hFFFF, 16'h1234);
    run_op(4'd12, 16'h0F0F, 16'hFFFF);
    run_op(4'd9, 16'h0007, 16'h0003);

    // R9: op write beats direct load in the same cycle; load wins when no write
    @(negedge clk);
    issue = 1'b1; op = 4'd0; opnd_b = 16'd1; opnd_a = 16'd1;
    aux_load = 1'b1; aux_load_val = 16'h1234;
    @(negedge clk);
    check("R9", aux_q === 16'h0000, "op write over load", aux_q, 16'h0000);
    op = 4'd11; aux_load_val = 16'h4321;
    @(negedge clk);
    check("R9", aux_q === 16'h4321, "load during OR", aux_q, 16'h4321);
    mdl_aux = 16'h4321;
    aux_load = 1'b0;

    // corner operand grid for every operation
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_op(4'(o), corner[i], corner[j]);

    // seeded random operands, random aux values and small shift amounts
    for (int n = 0; n < 2400; n++) begin
      logic [3:0]  o;
      logic [15:0] b, a;
      o = 4'($urandom_range(0, 15));
      b = 16'($urandom);
      a = 16'($urandom);
      if (o >= 4'd13 && ($urandom_range(0, 3) != 0)) a = 16'($urandom_range(0, 40));
      if ((o == 4'd2 || o == 4'd3) && ($urandom_range(0, 1) == 1))
        load_aux(16'($urandom));
      run_op(o, b, a);
    end

    @(negedge clk);
    issue = 1'b0;
    check("R9", aux_q === mdl_aux, "aux_q final", aux_q, mdl_aux);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule